// File: doc/BRIEF.md
# Immediate and Branch Target Generator

This combinational unit takes a 32-bit base-integer instruction word and the address that instruction was fetched from. It produces two values. The first is the immediate operand in full 32-bit form, recovered from whichever bit layout the instruction's format uses. The second is the program-relative destination of a conditional branch or a jump-and-link. The format is chosen only by the seven opcode bits in `instr_i[6:0]`.

An execute stage uses this block next to its register read. The immediate feeds the ALU's second operand for loads, stores, immediate arithmetic and upper-immediate loads. The target feeds the program counter's next-value selector, so no separate adder is needed. All other fields (register numbers, funct3, funct7) pass through without effect.

When an opcode carries no immediate, both outputs are zero. The target is also zero for every opcode except branches and jump-and-link. A downstream unit can therefore treat a zero target as "not a PC-relative transfer" without decoding the opcode again.

Top module: `imm_target_gen`

## Requirements
- R1: For opcodes 0000011 (load), 0010011 (immediate arithmetic) and 1100111 (register jump), `imm_o` is `instr_i[31:20]` sign-extended from `instr_i[31]`.
- R2: For opcode 0100011 (store), `imm_o` is the 12-bit value {`instr_i[31:25]`, `instr_i[11:7]`} sign-extended from `instr_i[31]`.
- R3: For opcode 1100011 (conditional branch), `imm_o` is {`instr_i[31]`, `instr_i[7]`, `instr_i[30:25]`, `instr_i[11:8]`, 0} sign-extended from `instr_i[31]`, so bit 0 is always 0.
- R4: For opcode 1101111 (jump-and-link), `imm_o` is {`instr_i[31]`, `instr_i[19:12]`, `instr_i[20]`, `instr_i[30:21]`, 0} sign-extended from `instr_i[31]`.
- R5: For opcodes 0110111 and 0010111 (upper-immediate forms), `imm_o` holds `instr_i[31:12]` in bits 31:12 and zeros in bits 11:0. For example, a field of 0x12345 gives 0x12345000.
- R6: For opcodes 1100011 and 1101111, `target_o` equals `pc_i + imm_o` modulo 2^32, with no overflow indication.
- R7: For every opcode other than 1100011 and 1101111, `target_o` is zero.
- R8: For any opcode not listed in R1 to R5 (for example register-register 0110011, system 1110011, fence 0001111, all-zero), `imm_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word; bits 6:0 select the format |
| pc_i | input | 32 | Address of the instruction in `instr_i` |
| imm_o | output | 32 | Sign-extended or upper-placed immediate operand |
| target_o | output | 32 | PC-relative branch or jump destination, zero otherwise |

## Verification
The directed patterns set every sign bit at both extremes: all-ones fields give -1, fields with only the top bit clear give the largest positive value, and fields with only the top bit set give the most negative value. These patterns expose a scrambled bit order or a wrong sign source in each layout. Targets are driven across the 2^32 wrap in both directions, which separates a modular adder from a saturating or carry-dropping one. Non-immediate opcodes are given dense random upper bits, which exposes any leak into either output. A random stream then picks both listed and unlisted opcodes, so that formats with overlapping fields (store against branch, upper-immediate against jump) are told apart on the same bit patterns.

// File: rtl/imm_gen_pkg.sv
package imm_gen_pkg;

    localparam int XLEN  = 32;
    localparam int OPC_W = 7;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_JREG   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_JLINK  = 7'b1101111;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5
    } imm_fmt_e;

endpackage

// File: rtl/imm_fmt_decode.sv
module imm_fmt_decode
    import imm_gen_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output imm_fmt_e         fmt_o,
    output logic             tgt_en_o
);

    always_comb begin
        unique case (opcode_i)
            OPC_LOAD, OPC_OPIMM, OPC_JREG: fmt_o = FMT_I;
            OPC_STORE:                     fmt_o = FMT_S;
            OPC_BRANCH:                    fmt_o = FMT_B;
            OPC_LUI, OPC_AUIPC:            fmt_o = FMT_U;
            OPC_JLINK:                     fmt_o = FMT_J;
            default:                       fmt_o = FMT_NONE;
        endcase
    end

    // Only relative control transfers produce a destination address.
    assign tgt_en_o = (fmt_o == FMT_B) || (fmt_o == FMT_J);

endmodule

// File: rtl/imm_field_extract.sv
module imm_field_extract
    import imm_gen_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [31:7]  body_i,
    input  imm_fmt_e     fmt_i,
    output logic [W-1:0] imm_o
);

    localparam int I_BITS = 12;
    localparam int B_BITS = 13;
    localparam int U_BITS = 20;
    localparam int J_BITS = 21;

    logic sgn;
    assign sgn = body_i[31];

    always_comb begin
        unique case (fmt_i)
            FMT_I: imm_o = {{(W-I_BITS){sgn}}, body_i[31:20]};
            FMT_S: imm_o = {{(W-I_BITS){sgn}}, body_i[31:25], body_i[11:7]};
            FMT_B: imm_o = {{(W-B_BITS){sgn}}, sgn, body_i[7], body_i[30:25],
                            body_i[11:8], 1'b0};
            FMT_U: imm_o = {{(W-32){sgn}}, body_i[31:12], {(32-U_BITS){1'b0}}};
            FMT_J: imm_o = {{(W-J_BITS){sgn}}, sgn, body_i[19:12], body_i[20],
                            body_i[30:21], 1'b0};
            default: imm_o = '0;
        endcase
    end

endmodule

// File: rtl/imm_target_adder.sv
module imm_target_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] ofs_i,
    input  logic         en_i,
    output logic [W-1:0] tgt_o
);

    logic [W-1:0] sum;

    // Carry out of the top bit is discarded: the address space wraps.
    assign sum   = pc_i + ofs_i;
    assign tgt_o = en_i ? sum : '0;

endmodule

// File: rtl/imm_target_gen.sv
module imm_target_gen
    import imm_gen_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] pc_i,
    output logic [31:0] imm_o,
    output logic [31:0] target_o
);

    imm_fmt_e fmt;
    logic     tgt_en;

    imm_fmt_decode u_dec (
        .opcode_i (instr_i[OPC_W-1:0]),
        .fmt_o    (fmt),
        .tgt_en_o (tgt_en)
    );

    imm_field_extract #(.W(XLEN)) u_ext (
        .body_i (instr_i[31:7]),
        .fmt_i  (fmt),
        .imm_o  (imm_o)
    );

    imm_target_adder #(.W(XLEN)) u_add (
        .pc_i  (pc_i),
        .ofs_i (imm_o),
        .en_i  (tgt_en),
        .tgt_o (target_o)
    );

endmodule

// File: rtl/imm_target_gen_chk.sv
module imm_target_gen_chk (
    input logic [31:0] instr_i,
    input logic [31:0] pc_i,
    input logic [31:0] imm_o,
    input logic [31:0] target_o
);

    logic [6:0] opc;
    logic       is_b, is_j, is_u, is_sext, is_none;

    assign opc     = instr_i[6:0];
    assign is_b    = (opc == 7'b1100011);
    assign is_j    = (opc == 7'b1101111);
    assign is_u    = (opc == 7'b0110111) || (opc == 7'b0010111);
    assign is_sext = (opc == 7'b0000011) || (opc == 7'b0010011) ||
                     (opc == 7'b1100111) || (opc == 7'b0100011) || is_b || is_j;
    assign is_none = !(is_sext || is_u);

    always_comb begin
        // R3
        b_even_chk: assert (!(is_b || is_j) || (imm_o[0] == 1'b0))
            else $error("branch/jump offset is odd");
        // R5
        u_low_zero_chk: assert (!is_u || (imm_o[11:0] == 12'h000))
            else $error("upper immediate has nonzero low bits");
        // R1
        sign_src_chk: assert (!is_sext || (imm_o[31] == instr_i[31]))
            else $error("sign bit not taken from instruction bit 31");
        // R6
        target_sum_chk: assert (!(is_b || is_j) || (target_o == pc_i + imm_o))
            else $error("target differs from pc plus offset");
        // R7
        target_idle_chk: assert ((is_b || is_j) || (target_o == 32'h0))
            else $error("target nonzero for non-transfer opcode");
        // R8
        no_imm_chk: assert (!is_none || (imm_o == 32'h0))
            else $error("immediate nonzero for immediate-free opcode");
    end

endmodule

bind imm_target_gen imm_target_gen_chk u_chk (
    .instr_i  (instr_i),
    .pc_i     (pc_i),
    .imm_o    (imm_o),
    .target_o (target_o)
);

// File: tb/imm_target_gen_bench.sv
module imm_target_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [31:0] pc = 32'h0;
    logic [31:0] imm_o, target_o;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam int WATCHDOG_CYC = 50000;

    always #10 clk = ~clk;

    imm_target_gen u_imm_target_gen (
        .instr_i  (instr),
        .pc_i     (pc),
        .imm_o    (imm_o),
        .target_o (target_o)
    );

    function automatic string req_of(input logic [6:0] op, input bit tgt);
        if (tgt) return (op == 7'h63 || op == 7'h6F) ? "R6" : "R7";
        case (op)
            7'h03, 7'h13, 7'h67: return "R1";
            7'h23:               return "R2";
            7'h63:               return "R3";
            7'h6F:               return "R4";
            7'h37, 7'h17:        return "R5";
            default:             return "R8";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic on the fields.
    function automatic void model(input logic [31:0] ins, input logic [31:0] p,
                                  output logic [31:0] e_imm, output logic [31:0] e_tgt);
        int v;
        v = 0;
        case (ins[6:0])
            7'h03, 7'h13, 7'h67: begin
                v = int'(ins[31:20]);
                if (v >= 2048) v = v - 4096;
            end
            7'h23: begin
                v = int'(ins[31:25]) * 32 + int'(ins[11:7]);
                if (v >= 2048) v = v - 4096;
            end
            7'h63: begin
                v = int'(ins[7]) * 2048 + int'(ins[30:25]) * 32 + int'(ins[11:8]) * 2;
                if (ins[31]) v = v - 4096;
            end
            7'h6F: begin
                v = int'(ins[19:12]) * 4096 + int'(ins[20]) * 2048 + int'(ins[30:21]) * 2;
                if (ins[31]) v = v - (1 << 20);
            end
            default: v = 0;
        endcase
        if (ins[6:0] == 7'h37 || ins[6:0] == 7'h17) e_imm = ins & 32'hFFFF_F000;
        else e_imm = 32'(v);
        if (ins[6:0] == 7'h63 || ins[6:0] == 7'h6F) e_tgt = p + e_imm;
        else e_tgt = 32'h0;
    endfunction

    // Compare against the model on every clock, away from the driving edge.
    always @(negedge clk) begin
        logic [31:0] e_imm, e_tgt;
        if (!done) begin
            model(instr, pc, e_imm, e_tgt);
            n_run++;
            if (imm_o !== e_imm) begin
                n_fail++;
                $display("FAIL %s imm instr=%h: actual %h expected %h",
                         req_of(instr[6:0], 1'b0), instr, imm_o, e_imm);
            end
            n_run++;
            if (target_o !== e_tgt) begin
                n_fail++;
                $display("FAIL %s target instr=%h pc=%h: actual %h expected %h",
                         req_of(instr[6:0], 1'b1), instr, pc, target_o, e_tgt);
            end
        end
    end

    task automatic apply(input logic [31:0] ins, input logic [31:0] p);
        @(posedge clk);
        #2;
        instr = ins;
        pc    = p;
    endtask

    initial begin
        logic [6:0] ops [12];
        ops = '{7'h03, 7'h13, 7'h67, 7'h23, 7'h63, 7'h6F,
                7'h37, 7'h17, 7'h33, 7'h73, 7'h0F, 7'h00};
        // Reset state: all-zero instruction gives zero outputs (R8, R7).
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1: -1, largest positive, most negative
        apply(32'hFFF0_0013, 32'h0000_1000);
        apply(32'h7FF0_0003, 32'h0000_1000);
        apply(32'h8000_0067, 32'h0000_1000);
        // R2: store with split fields
        apply(32'hFE00_0FA3, 32'h0);
        apply(32'h7E00_0FA3, 32'h0);
        apply(32'h8000_0023, 32'h0);
        // R3 and R6: branch offsets, wrap below zero and above top
        apply(32'h8000_0063, 32'h0000_0010);
        apply(32'h7E00_0FE3, 32'hFFFF_FF00);
        apply(32'hFFFF_FFE3, 32'h0000_0000);
        apply(32'h0000_0F63, 32'h1234_5678);
        // R4 and R6: jump offsets
        apply(32'h8000_006F, 32'h0000_0100);
        apply(32'h7FFF_F0EF, 32'hFFFF_FFF0);
        apply(32'h0010_006F, 32'h0000_0040);
        apply(32'h000F_F06F, 32'h0);
        // R5 and R7: upper immediates, target stays zero
        apply(32'h1234_53B7, 32'h0000_4000);
        apply(32'hFFFF_F097, 32'h0000_4000);
        // R8 and R7: no-immediate opcodes with dense upper bits
        apply(32'hFFFF_FFB3, 32'hFFFF_FFFF);
        apply(32'hFFFF_FFF3, 32'h8000_0000);
        apply(32'hFFFF_FF8F, 32'h0000_0004);
        // Random stream across listed and unlisted opcodes
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] r;
            r = $urandom;
            r[6:0] = ops[$urandom % 12];
            apply(r, $urandom);
        end
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule